// File: doc/BRIEF.md
# Machine-Mode Trap Register Unit

This unit keeps the machine-level trap state of a small 32-bit core. It holds six registers: a reduced status word (global interrupt enable and its saved copy), the trap base, the saved exception PC, the trap cause, the trap value and a scratch word. Software reaches them through a command port that carries a 12-bit register address, an operation code, an operand and a stall flag. Each command returns the old register value in the same cycle. Addresses that match no register are flagged as illegal.

When an exception, an interrupt or a trap return is signalled, the unit drives the redirect PC in the same cycle and updates its trap registers at the next clock edge. Exceptions always go to the trap base. Interrupts are dispatched through a vector table at the base plus four times the interrupt number. A return goes back to the saved PC. A small state machine makes sure that a modifying command held over a pipeline stall changes its register only once. The gate has two states. GATE_OPEN moves to GATE_SPENT on the *consume* transition, taken when a modifying command is applied while the stall flag is high. GATE_SPENT moves back to GATE_OPEN on the *release* transition, taken when the stall drops or the request is withdrawn. The redirect selector picks one of four outcomes, in this order of precedence: TGT_EXC, TGT_IRQ, TGT_RET and TGT_NONE.

Top module: `trap_csr_unit`

## Requirements
- R1: An exception raises `pc_set_o` in the same cycle with `pc_next_o` equal to the trap base (mode bits cleared). From the next cycle, the cause register reads bit 31 = 0 and bits 4:0 = the exception code.
- R2: An interrupt without an exception redirects to the trap base plus 4 × `irq_id_i` in the same cycle. From the next cycle, the cause register reads bit 31 = 1 and bits 4:0 = the interrupt number.
- R3: The trap base register (address 0x305) always reads bits 1:0 as 2'b01 (vectored), whatever software writes. Bits 31:2 hold the written base.
- R4: A trap writes the trap value register (0x343) as follows: the faulting data address for a load/store error, the instruction word for an illegal instruction, and zero for an interrupt or any other exception. Software may read and write it freely.
- R5: The saved PC register (0x341) forces bit 0 to zero, both on software writes and when it captures `trap_pc_i` at trap entry.
- R6: A write, set or clear command that is held asserted across stalled cycles modifies its register in the first cycle only.
- R7: The scratch register (0x340) is a plain 32-bit read/write word with no side effects.
- R8: The operation codes are 2'b00 read, 2'b01 write, 2'b10 set (OR the operand in) and 2'b11 clear (AND with the operand's inverse). Every operation returns the register's old value on `csr_rdata_o` in the same cycle. The new value is visible from the next cycle.
- R9: The cause register (0x342) reads bit 31 as the interrupt flag and bits 4:0 as the cause code. All other bits read zero, including after a software write.
- R10: A request to any other address raises `csr_illegal_o` in the same cycle, returns zero and changes no register.
- R11: The status register (0x300) holds the enable in bit 3 and its saved copy in bit 7. Any trap copies the enable into the saved copy and clears the enable. A return (`mret_i`) restores the enable from the saved copy, sets the saved copy to 1 and redirects to the saved PC.
- R12: Precedence is exception over interrupt over return. Any trap or return suppresses a CSR modification in the same cycle.
- R13: After reset, the trap base reads `BOOT_BASE` with mode 01 (0x00000101 by default), all other registers read zero, and `pc_set_o`, `csr_illegal_o` and `csr_rdata_o` are low when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_req_i | input | 1 | CSR command valid |
| csr_op_i | input | 2 | Operation: 00 read, 01 write, 10 set, 11 clear |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | 32 | Operand |
| stall_i | input | 1 | Pipeline stall; the command is held while high |
| csr_rdata_o | output | 32 | Old value of the addressed register |
| csr_illegal_o | output | 1 | Request hit no implemented register |
| exc_valid_i | input | 1 | Exception taken this cycle |
| exc_cause_i | input | 5 | Exception code |
| exc_lsu_err_i | input | 1 | Exception is a load/store error |
| exc_illegal_instr_i | input | 1 | Exception is an illegal instruction |
| fault_addr_i | input | 32 | Failing data address |
| fault_instr_i | input | 32 | Offending instruction word |
| irq_valid_i | input | 1 | Interrupt taken this cycle |
| irq_id_i | input | 5 | Interrupt number |
| trap_pc_i | input | 32 | PC of the trapping instruction |
| mret_i | input | 1 | Trap return strobe |
| pc_set_o | output | 1 | Redirect the fetch this cycle |
| pc_next_o | output | 32 | Redirect target |
| irq_enable_o | output | 1 | Current global interrupt enable |

## Verification
Read data, the illegal flag and the redirect target are combinational, so they are due in the cycle a command or trap is presented. The bench drives at the falling edge and samples 2 ns later, before the rising edge. Register updates from a write, set, clear or trap land at the following rising edge. They are therefore checked through a separate read issued in a later cycle. The stall test spans four cycles: an applied write, a trap, a further held cycle and a release. It then reads the saved PC to tell a single modification from a repeated one.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;
    localparam int XLEN       = 32;
    localparam int CSR_ADDR_W = 12;
    localparam int NUM_CSR    = 6;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    typedef enum logic {
        GATE_OPEN,
        GATE_SPENT
    } gate_state_e;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_EXC,
        TGT_IRQ,
        TGT_RET
    } target_e;

    localparam int SEL_STATUS  = 0;
    localparam int SEL_TVEC    = 1;
    localparam int SEL_EPC     = 2;
    localparam int SEL_CAUSE   = 3;
    localparam int SEL_TVAL    = 4;
    localparam int SEL_SCRATCH = 5;

    localparam logic [CSR_ADDR_W-1:0] CSR_ADDRS [NUM_CSR] = '{
        12'h300, 12'h305, 12'h341, 12'h342, 12'h343, 12'h340
    };

    localparam int IE_BIT       = 3;
    localparam int SAVED_IE_BIT = 7;
    localparam logic [1:0] MODE_VECTORED = 2'b01;
endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import trap_csr_pkg::*;
(
    input  logic [CSR_ADDR_W-1:0] addr_i,
    output logic [NUM_CSR-1:0]    sel_o,
    output logic                  hit_o
);
    for (genvar i = 0; i < NUM_CSR; i++) begin : g_match
        assign sel_o[i] = (addr_i == CSR_ADDRS[i]);
    end
    assign hit_o = |sel_o;
endmodule

// File: rtl/csr_cmd_gate.sv
module csr_cmd_gate
    import trap_csr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cmd_valid_i,
    input  logic req_i,
    input  logic stall_i,
    output logic apply_o
);
    gate_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= GATE_OPEN;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OPEN:  if (cmd_valid_i && stall_i) state_d = GATE_SPENT;
            GATE_SPENT: if (!stall_i || !req_i)     state_d = GATE_OPEN;
            default:    state_d = GATE_OPEN;
        endcase
    end

    always_comb begin
        apply_o = 1'b0;
        unique case (state_q)
            GATE_OPEN:  apply_o = cmd_valid_i;
            GATE_SPENT: apply_o = 1'b0;
            default:    apply_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/trap_target.sv
module trap_target
    import trap_csr_pkg::*;
#(
    parameter int CAUSE_W = 5
) (
    input  logic               exc_valid_i,
    input  logic               irq_valid_i,
    input  logic               ret_i,
    input  logic [CAUSE_W-1:0] irq_id_i,
    input  logic [XLEN-3:0]    base_i,
    input  logic [XLEN-1:0]    epc_i,
    output target_e            kind_o,
    output logic               pc_set_o,
    output logic [XLEN-1:0]    pc_next_o
);
    localparam int PAD_W = XLEN - CAUSE_W - 2;

    logic [XLEN-1:0] base_addr, vec_offset;
    assign base_addr  = {base_i, 2'b00};
    assign vec_offset = {{PAD_W{1'b0}}, irq_id_i, 2'b00};

    always_comb begin
        if (exc_valid_i)      kind_o = TGT_EXC;
        else if (irq_valid_i) kind_o = TGT_IRQ;
        else if (ret_i)       kind_o = TGT_RET;
        else                  kind_o = TGT_NONE;
    end

    always_comb begin
        pc_set_o  = 1'b1;
        pc_next_o = '0;
        unique case (kind_o)
            TGT_EXC:  pc_next_o = base_addr;
            TGT_IRQ:  pc_next_o = base_addr + vec_offset;
            TGT_RET:  pc_next_o = epc_i;
            TGT_NONE: pc_set_o  = 1'b0;
            default:  pc_set_o  = 1'b0;
        endcase
    end
endmodule

// File: rtl/trap_csr_unit.sv
module trap_csr_unit
    import trap_csr_pkg::*;
#(
    parameter int          CAUSE_W   = 5,
    parameter logic [31:0] BOOT_BASE = 32'h0000_0100
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               csr_req_i,
    input  logic [1:0]         csr_op_i,
    input  logic [11:0]        csr_addr_i,
    input  logic [31:0]        csr_wdata_i,
    input  logic               stall_i,
    output logic [31:0]        csr_rdata_o,
    output logic               csr_illegal_o,
    input  logic               exc_valid_i,
    input  logic [CAUSE_W-1:0] exc_cause_i,
    input  logic               exc_lsu_err_i,
    input  logic               exc_illegal_instr_i,
    input  logic [31:0]        fault_addr_i,
    input  logic [31:0]        fault_instr_i,
    input  logic               irq_valid_i,
    input  logic [CAUSE_W-1:0] irq_id_i,
    input  logic [31:0]        trap_pc_i,
    input  logic               mret_i,
    output logic               pc_set_o,
    output logic [31:0]        pc_next_o,
    output logic               irq_enable_o
);
    localparam int CAUSE_PAD = XLEN - 1 - CAUSE_W;

    logic [NUM_CSR-1:0] sel;
    logic               hit, gate_apply, cmd_valid;
    target_e            kind;
    csr_op_e            op;

    logic               mie_q, mpie_q, mcause_flag_q;
    logic [XLEN-3:0]    tvec_base_q;
    logic [XLEN-1:0]    epc_q, tval_q, scratch_q;
    logic [CAUSE_W-1:0] mcause_code_q;
    logic [XLEN-1:0]    cur_val, new_val;

    assign op = csr_op_e'(csr_op_i);

    csr_addr_decode i_decode (.addr_i(csr_addr_i), .sel_o(sel), .hit_o(hit));

    assign cmd_valid = csr_req_i && hit && (op != OP_READ);

    csr_cmd_gate i_gate (
        .clk_i, .rst_ni, .cmd_valid_i(cmd_valid), .req_i(csr_req_i),
        .stall_i, .apply_o(gate_apply)
    );

    trap_target #(.CAUSE_W(CAUSE_W)) i_target (
        .exc_valid_i, .irq_valid_i, .ret_i(mret_i), .irq_id_i,
        .base_i(tvec_base_q), .epc_i(epc_q), .kind_o(kind),
        .pc_set_o, .pc_next_o
    );

    always_comb begin
        cur_val = '0;
        if (sel[SEL_STATUS]) begin
            cur_val[IE_BIT]       = mie_q;
            cur_val[SAVED_IE_BIT] = mpie_q;
        end
        if (sel[SEL_TVEC])    cur_val = {tvec_base_q, MODE_VECTORED};
        if (sel[SEL_EPC])     cur_val = epc_q;
        if (sel[SEL_CAUSE])   cur_val = {mcause_flag_q, {CAUSE_PAD{1'b0}}, mcause_code_q};
        if (sel[SEL_TVAL])    cur_val = tval_q;
        if (sel[SEL_SCRATCH]) cur_val = scratch_q;
    end

    always_comb begin
        unique case (op)
            OP_WRITE: new_val = csr_wdata_i;
            OP_SET:   new_val = cur_val | csr_wdata_i;
            OP_CLEAR: new_val = cur_val & ~csr_wdata_i;
            default:  new_val = cur_val;
        endcase
    end

    assign csr_rdata_o   = (csr_req_i && hit) ? cur_val : '0;
    assign csr_illegal_o = csr_req_i && !hit;
    assign irq_enable_o  = mie_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mie_q         <= 1'b0;
            mpie_q        <= 1'b0;
            tvec_base_q   <= BOOT_BASE[XLEN-1:2];
            epc_q         <= '0;
            mcause_flag_q <= 1'b0;
            mcause_code_q <= '0;
            tval_q        <= '0;
            scratch_q     <= '0;
        end else begin
            unique case (kind)
                TGT_EXC: begin
                    epc_q         <= {trap_pc_i[XLEN-1:1], 1'b0};
                    mcause_flag_q <= 1'b0;
                    mcause_code_q <= exc_cause_i;
                    tval_q        <= exc_lsu_err_i       ? fault_addr_i  :
                                     exc_illegal_instr_i ? fault_instr_i : '0;
                    mpie_q        <= mie_q;
                    mie_q         <= 1'b0;
                end
                TGT_IRQ: begin
                    epc_q         <= {trap_pc_i[XLEN-1:1], 1'b0};
                    mcause_flag_q <= 1'b1;
                    mcause_code_q <= irq_id_i;
                    tval_q        <= '0;
                    mpie_q        <= mie_q;
                    mie_q         <= 1'b0;
                end
                TGT_RET: begin
                    mie_q  <= mpie_q;
                    mpie_q <= 1'b1;
                end
                default: begin
                    if (gate_apply) begin
                        if (sel[SEL_STATUS]) begin
                            mie_q  <= new_val[IE_BIT];
                            mpie_q <= new_val[SAVED_IE_BIT];
                        end
                        if (sel[SEL_TVEC])    tvec_base_q <= new_val[XLEN-1:2];
                        if (sel[SEL_EPC])     epc_q       <= {new_val[XLEN-1:1], 1'b0};
                        if (sel[SEL_CAUSE]) begin
                            mcause_flag_q <= new_val[XLEN-1];
                            mcause_code_q <= new_val[CAUSE_W-1:0];
                        end
                        if (sel[SEL_TVAL])    tval_q      <= new_val;
                        if (sel[SEL_SCRATCH]) scratch_q   <= new_val;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/trap_csr_checker.sv
module trap_csr_checker
    import trap_csr_pkg::*;
(
    input logic        clk_i,
    input logic        rst_ni,
    input logic        csr_req_i,
    input logic [11:0] csr_addr_i,
    input logic [31:0] csr_rdata_o,
    input logic        csr_illegal_o,
    input logic        stall_i,
    input logic        gate_apply,
    input logic        exc_valid_i,
    input logic        irq_valid_i,
    input logic        mcause_flag_q,
    input logic        mie_q
);
    AST_TVEC_MODE_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_req_i && csr_addr_i == CSR_ADDRS[SEL_TVEC]) |-> csr_rdata_o[1:0] == MODE_VECTORED); // R3

    AST_EPC_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_req_i && csr_addr_i == CSR_ADDRS[SEL_EPC]) |-> !csr_rdata_o[0]); // R5

    AST_SINGLE_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_req_i && $past(csr_req_i) && $past(stall_i) && $past(gate_apply)) |-> !gate_apply); // R6

    AST_ILLEGAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        csr_illegal_o |-> (csr_rdata_o == '0 && !gate_apply)); // R10

    AST_EXC_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_valid_i |=> !mcause_flag_q); // R1

    AST_IRQ_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_valid_i && !exc_valid_i) |=> mcause_flag_q); // R2

    AST_TRAP_MASKS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_valid_i || irq_valid_i) |=> !mie_q); // R11
endmodule

bind trap_csr_unit trap_csr_checker i_trap_csr_checker (.*);

// File: tb/test_trap_csr_unit.sv
module test_trap_csr_unit;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        csr_req_i = 1'b0;
    logic [1:0]  csr_op_i = '0;
    logic [11:0] csr_addr_i = '0;
    logic [31:0] csr_wdata_i = '0;
    logic        stall_i = 1'b0;
    logic [31:0] csr_rdata_o;
    logic        csr_illegal_o;
    logic        exc_valid_i = 1'b0;
    logic [4:0]  exc_cause_i = '0;
    logic        exc_lsu_err_i = 1'b0;
    logic        exc_illegal_instr_i = 1'b0;
    logic [31:0] fault_addr_i = '0;
    logic [31:0] fault_instr_i = '0;
    logic        irq_valid_i = 1'b0;
    logic [4:0]  irq_id_i = '0;
    logic [31:0] trap_pc_i = '0;
    logic        mret_i = 1'b0;
    logic        pc_set_o;
    logic [31:0] pc_next_o;
    logic        irq_enable_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk_i = ~clk_i;

    trap_csr_unit i_trap_csr_unit (.*);

    localparam logic [1:0] RD = 2'b00, WR = 2'b01, ST = 2'b10, CL = 2'b11;
    localparam logic [11:0] A_STAT = 12'h300, A_TVEC = 12'h305, A_SCR = 12'h340,
                            A_EPC = 12'h341, A_CAUSE = 12'h342, A_TVAL = 12'h343;

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic        exp_ill;
    } vec_t;

    localparam int NVEC = 23;
    localparam vec_t VECS [NVEC] = '{
        '{WR, A_SCR,   32'hDEADBEEF, 32'h00000000, 1'b0}, // R7 R8
        '{RD, A_SCR,   32'h0,        32'hDEADBEEF, 1'b0}, // R7
        '{ST, A_SCR,   32'h00000010, 32'hDEADBEEF, 1'b0}, // R8 set
        '{CL, A_SCR,   32'hFF000000, 32'hDEADBEFF, 1'b0}, // R8 clear
        '{RD, A_SCR,   32'h0,        32'h00ADBEFF, 1'b0}, // R8
        '{RD, A_TVEC,  32'h0,        32'h00000101, 1'b0}, // R13
        '{WR, A_TVEC,  32'h00002000, 32'h00000101, 1'b0}, // R3
        '{RD, A_TVEC,  32'h0,        32'h00002001, 1'b0}, // R3
        '{WR, A_TVEC,  32'h00003002, 32'h00002001, 1'b0}, // R3
        '{RD, A_TVEC,  32'h0,        32'h00003001, 1'b0}, // R3
        '{WR, A_EPC,   32'h00001235, 32'h00000000, 1'b0}, // R5 R13
        '{RD, A_EPC,   32'h0,        32'h00001234, 1'b0}, // R5
        '{WR, A_CAUSE, 32'h800000FF, 32'h00000000, 1'b0}, // R9
        '{RD, A_CAUSE, 32'h0,        32'h8000001F, 1'b0}, // R9
        '{WR, A_STAT,  32'hFFFFFFFF, 32'h00000000, 1'b0}, // R11
        '{RD, A_STAT,  32'h0,        32'h00000088, 1'b0}, // R11
        '{CL, A_STAT,  32'h00000008, 32'h00000088, 1'b0}, // R11
        '{RD, A_STAT,  32'h0,        32'h00000080, 1'b0}, // R11
        '{RD, 12'h7C0, 32'h0,        32'h00000000, 1'b1}, // R10
        '{WR, 12'h344, 32'h00000001, 32'h00000000, 1'b1}, // R10
        '{WR, A_TVAL,  32'h00000055, 32'h00000000, 1'b0}, // R4
        '{RD, A_TVAL,  32'h0,        32'h00000055, 1'b0}, // R4
        '{RD, A_SCR,   32'h0,        32'h00ADBEFF, 1'b0}  // R10 no change
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_traps();
        exc_valid_i = 1'b0; irq_valid_i = 1'b0; mret_i = 1'b0;
        exc_lsu_err_i = 1'b0; exc_illegal_instr_i = 1'b0;
    endtask

    task automatic csr_access(input logic [1:0] op, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk_i);
        clear_traps();
        stall_i = 1'b0;
        csr_req_i = 1'b1; csr_op_i = op; csr_addr_i = a; csr_wdata_i = d;
        #2;
    endtask

    task automatic read_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        csr_access(RD, a, 32'h0);
        check(req, csr_rdata_o, exp);
    endtask

    task automatic trap(input logic exc, input logic irq, input logic ret,
                        input logic [4:0] cause, input logic [4:0] id, input logic [31:0] pc,
                        input logic lsu, input logic ill);
        @(negedge clk_i);
        csr_req_i = 1'b0; stall_i = 1'b0;
        exc_valid_i = exc; irq_valid_i = irq; mret_i = ret;
        exc_cause_i = cause; irq_id_i = id; trap_pc_i = pc;
        exc_lsu_err_i = lsu; exc_illegal_instr_i = ill;
        #2;
    endtask

    initial begin
        #(8 * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        fault_addr_i  = 32'hABCD0003;
        fault_instr_i = 32'h00F00013;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        #2;
        check("R13 pc_set idle",  {31'b0, pc_set_o}, 32'h0);
        check("R13 illegal idle", {31'b0, csr_illegal_o}, 32'h0);
        check("R13 rdata idle",   csr_rdata_o, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            csr_access(VECS[i].op, VECS[i].addr, VECS[i].wdata);
            check($sformatf("R8 vector %0d rdata", i), csr_rdata_o, VECS[i].exp_rd);
            check($sformatf("R10 vector %0d illegal", i), {31'b0, csr_illegal_o}, {31'b0, VECS[i].exp_ill});
        end

        csr_access(WR, A_STAT, 32'h00000008);
        read_check("R11 enable set", A_STAT, 32'h00000008);
        check("R11 enable port", {31'b0, irq_enable_o}, 32'h1);

        trap(1'b1, 1'b0, 1'b0, 5'd5, 5'd0, 32'h00000400, 1'b1, 1'b0);
        check("R1 exc pc_set", {31'b0, pc_set_o}, 32'h1);
        check("R1 exc target", pc_next_o, 32'h00003000);
        read_check("R1 exc cause", A_CAUSE, 32'h00000005);
        read_check("R4 lsu tval", A_TVAL, 32'hABCD0003);
        read_check("R5 epc capture", A_EPC, 32'h00000400);
        read_check("R11 trap status", A_STAT, 32'h00000080);

        trap(1'b0, 1'b0, 1'b1, 5'd0, 5'd0, 32'h0, 1'b0, 1'b0);
        check("R11 ret target", pc_next_o, 32'h00000400);
        read_check("R11 ret status", A_STAT, 32'h00000088);

        trap(1'b1, 1'b0, 1'b0, 5'd2, 5'd0, 32'h00000503, 1'b0, 1'b1);
        check("R1 ill target", pc_next_o, 32'h00003000);
        read_check("R4 instr tval", A_TVAL, 32'h00F00013);
        read_check("R5 epc odd pc", A_EPC, 32'h00000502);

        trap(1'b0, 1'b1, 1'b0, 5'd0, 5'd7, 32'h00000600, 1'b0, 1'b0);
        check("R2 irq target", pc_next_o, 32'h0000301C);
        read_check("R2 R9 irq cause", A_CAUSE, 32'h80000007);
        read_check("R4 irq tval", A_TVAL, 32'h00000000);

        trap(1'b1, 1'b1, 1'b1, 5'd11, 5'd3, 32'h00000700, 1'b0, 1'b0);
        csr_req_i = 1'b1; csr_op_i = WR; csr_addr_i = A_SCR; csr_wdata_i = 32'h00001111;
        check("R12 priority target", pc_next_o, 32'h00003000);
        read_check("R12 priority cause", A_CAUSE, 32'h0000000B);
        read_check("R12 write suppressed", A_SCR, 32'h00ADBEFF);

        // R6: write held over stall, trap in between, write must not reapply
        @(negedge clk_i);
        clear_traps();
        csr_req_i = 1'b1; csr_op_i = WR; csr_addr_i = A_EPC; csr_wdata_i = 32'h00000700; stall_i = 1'b1;
        @(negedge clk_i);
        exc_valid_i = 1'b1; exc_cause_i = 5'd4; trap_pc_i = 32'h00000900;
        @(negedge clk_i);
        exc_valid_i = 1'b0;
        @(negedge clk_i);
        stall_i = 1'b0;
        read_check("R6 single effect", A_EPC, 32'h00000900);

        @(negedge clk_i);
        csr_req_i = 1'b0;
        clear_traps();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule